// File: doc/BRIEF.md
# Isochronous Resource Lock Register File

This block holds the four shared resource registers that the resource manager node of a serial bus exposes to every other node: the bus manager identity, the remaining isochronous bandwidth, and two 32-bit masks of free isochronous channels. Other nodes claim and release resources by sending lock requests. A decoded request arrives on the request port with an operation, a byte offset, a length, an extended lock code, a data value and an argument value. The block answers one cycle later with a response code and a returned quadlet.

Only compare-swap locks are served. Not all of them mean a literal compare-and-swap. The bandwidth register uses a bounded subtract/add rule. The channel masks toggle only the bits in which data and argument differ, and only when the register agrees with the argument on those bits. The channel mask that holds broadcast channel 31 never lets that channel be released. Plain reads return the current contents, and plain writes are refused. A bus reset input reloads all four registers to their defaults.

Top module: `irm_lock_regs`

## Requirements
- R1: After `rst_n` is deasserted, or one cycle after `bus_reset` is high, the registers hold these defaults: manager identity 0x3F, bandwidth 4915, upper channel mask 0xFFFFFFFE, lower channel mask 0xFFFFFFFF.
- R2: Each request with `req_valid` high and `bus_reset` low gets exactly one response, with `rsp_valid` high for the single following cycle. A request made in the same cycle as `bus_reset` gets no response and changes nothing.
- R3: A read (op 0) at `REG_BASE`+0, +4, +8 or +12 returns the manager identity, the bandwidth, the upper channel mask or the lower channel mask, in that order, with code 0 (complete).
- R4: A write (op 1) to any of the four registers returns code 6 (type error) and value 0, and leaves the register unchanged. Any operation at an offset outside the four registers returns code 7 (address error).
- R5: An offset or length that is not a multiple of four, a zero length, or the reserved op 3 returns code 6. The type error wins over the address error.
- R6: A lock (op 2) whose extended code is not `CAS_CODE` (default 2) returns code 6 and changes nothing.
- R7: A lock on the manager identity returns the old value and loads the data only when the old value equals the argument.
- R8: A bandwidth lock with argument equal to data returns the old value and changes nothing.
- R9: A bandwidth lock with argument greater than data allocates (argument − data) units. If the old value is at least that amount, the register is reduced by it and the argument is returned. Otherwise the old value is returned and the register is kept.
- R10: A bandwidth lock with data greater than argument frees (data − argument) units. If the sum stays below `BW_LIMIT` (8192), the register is updated and the argument is returned. Otherwise the old value is returned and the register is kept.
- R11: A channel lock takes the affected bits as argument XOR data. If the register equals the argument on those bits, the register flips them and the argument is returned. Otherwise the current register is returned unchanged.
- R12: On the upper channel mask, data bit 0 (broadcast channel 31) is forced to 0 before the rule of R11 is applied, so that bit is never released.
- R13: Locks return code 0, and each lock completes its read, compare and update in one cycle, so the next request sees the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous reload of the register defaults |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 lock, 3 reserved |
| req_offset | input | OFS_W | Byte offset within the register space |
| req_len | input | LEN_W | Request length in bytes |
| req_ext | input | EXT_W | Extended lock code |
| req_data | input | 32 | Lock data value |
| req_arg | input | 32 | Lock argument value |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_code | output | 4 | 0 complete, 6 type error, 7 address error |
| rsp_value | output | 32 | Returned quadlet, 0 on error |

## Verification
The bench builds the block with its default parameters: base offset 0x21C, a bandwidth ceiling of 8192, a reset bandwidth of 4915 and the broadcast protection mask on bit 0. With these values one lock can drain the bandwidth to exactly zero and the next can refill it to exactly 8191, so both edges of the bound are reached in a few requests. The protection on channel 31 is exercised by a request that frees only that bit and by one that frees it together with another channel.

// File: rtl/irm_lock_pkg.sv
package irm_lock_pkg;

  localparam int QW = 32;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  localparam logic [3:0] RC_DONE = 4'd0;
  localparam logic [3:0] RC_TYPE = 4'd6;
  localparam logic [3:0] RC_ADDR = 4'd7;

  // register slot order, decoded from offset bits [3:2]
  localparam logic [1:0] SLOT_MGR = 2'd0;
  localparam logic [1:0] SLOT_BW  = 2'd1;
  localparam logic [1:0] SLOT_CHH = 2'd2;
  localparam logic [1:0] SLOT_CHL = 2'd3;

  typedef struct packed {
    logic          ok;
    logic [QW-1:0] nxt;
    logic [QW-1:0] ret;
  } lock_res_t;

  // bounded add/subtract rule for the bandwidth register
  function automatic lock_res_t bw_rule(input logic [QW-1:0] old_v,
                                        input logic [QW-1:0] dat,
                                        input logic [QW-1:0] arg,
                                        input logic [QW:0]   limit);
    lock_res_t  r;
    logic [QW:0] amt;
    logic [QW:0] sum;
    r.ok  = 1'b0;
    r.nxt = old_v;
    r.ret = old_v;
    amt   = '0;
    sum   = '0;
    if (arg > dat) begin
      amt = {1'b0, arg} - {1'b0, dat};
      if ({1'b0, old_v} >= amt) begin
        r.ok  = 1'b1;
        r.nxt = old_v - amt[QW-1:0];
        r.ret = arg;
      end
    end else if (dat > arg) begin
      amt = {1'b0, dat} - {1'b0, arg};
      sum = {1'b0, old_v} + amt;
      if (sum < limit) begin
        r.ok  = 1'b1;
        r.nxt = sum[QW-1:0];
        r.ret = arg;
      end
    end
    return r;
  endfunction

  // affected-bit toggle rule for a channel mask
  function automatic lock_res_t chan_rule(input logic [QW-1:0] old_v,
                                          input logic [QW-1:0] dat,
                                          input logic [QW-1:0] arg,
                                          input logic [QW-1:0] protect);
    lock_res_t     r;
    logic [QW-1:0] d_eff;
    logic [QW-1:0] aff;
    d_eff = dat & ~protect;
    aff   = arg ^ d_eff;
    if ((arg & aff) == (old_v & aff)) begin
      r.ok  = 1'b1;
      r.nxt = old_v ^ aff;
      r.ret = arg;
    end else begin
      r.ok  = 1'b0;
      r.nxt = old_v;
      r.ret = old_v;
    end
    return r;
  endfunction

endpackage

// File: rtl/irm_addr_decode.sv
module irm_addr_decode #(
  parameter int          OFS_W    = 12,
  parameter int          LEN_W    = 16,
  parameter int unsigned REG_BASE = 540
) (
  input  logic [OFS_W-1:0] offset_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             aligned_o,
  output logic             hit_o,
  output logic [1:0]       slot_o
);
  localparam logic [OFS_W-1:0] BASE = OFS_W'(REG_BASE);

  logic [OFS_W-1:0] rel;

  always_comb begin
    rel       = offset_i - BASE;
    aligned_o = (rel[1:0] == 2'b00) && (len_i[1:0] == 2'b00) && (len_i != '0);
    hit_o     = (rel[OFS_W-1:4] == '0);
    slot_o    = rel[3:2];
  end
endmodule

// File: rtl/irm_bw_unit.sv
module irm_bw_unit
  import irm_lock_pkg::*;
#(
  parameter int unsigned BW_LIMIT = 8192
) (
  input  logic [QW-1:0] old_i,
  input  logic [QW-1:0] dat_i,
  input  logic [QW-1:0] arg_i,
  output logic          ok_o,
  output logic [QW-1:0] nxt_o,
  output logic [QW-1:0] ret_o
);
  localparam logic [QW:0] LIMIT = (QW+1)'(BW_LIMIT);

  lock_res_t res;

  always_comb begin
    res   = bw_rule(old_i, dat_i, arg_i, LIMIT);
    ok_o  = res.ok;
    nxt_o = res.nxt;
    ret_o = res.ret;
  end
endmodule

// File: rtl/irm_chan_unit.sv
module irm_chan_unit
  import irm_lock_pkg::*;
#(
  parameter logic [31:0] PROTECT = 32'h0
) (
  input  logic [QW-1:0] old_i,
  input  logic [QW-1:0] dat_i,
  input  logic [QW-1:0] arg_i,
  output logic          ok_o,
  output logic [QW-1:0] nxt_o,
  output logic [QW-1:0] ret_o
);
  lock_res_t res;

  always_comb begin
    res   = chan_rule(old_i, dat_i, arg_i, PROTECT);
    ok_o  = res.ok;
    nxt_o = res.nxt;
    ret_o = res.ret;
  end
endmodule

// File: rtl/irm_lock_regs.sv
module irm_lock_regs
  import irm_lock_pkg::*;
#(
  parameter int          OFS_W         = 12,
  parameter int          LEN_W         = 16,
  parameter int          EXT_W         = 16,
  parameter int unsigned REG_BASE      = 540,
  parameter int unsigned CAS_CODE      = 2,
  parameter logic [31:0] MGR_RESET     = 32'h0000_003F,
  parameter int unsigned BW_RESET      = 4915,
  parameter int unsigned BW_LIMIT      = 8192,
  parameter logic [31:0] CHAN_HI_RESET = 32'hFFFF_FFFE,
  parameter logic [31:0] CHAN_LO_RESET = 32'hFFFF_FFFF,
  parameter logic [31:0] BCAST_MASK    = 32'h0000_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic [EXT_W-1:0] req_ext,
  input  logic [31:0]      req_data,
  input  logic [31:0]      req_arg,
  output logic             rsp_valid,
  output logic [3:0]       rsp_code,
  output logic [31:0]      rsp_value
);
  localparam int           NCH     = 2;
  localparam logic [EXT_W-1:0] CAS = EXT_W'(CAS_CODE);
  localparam logic [QW-1:0] BW_DEF = QW'(BW_RESET);

  // architectural state
  logic [QW-1:0] mgr_q;
  logic [QW-1:0] bw_q;
  logic [QW-1:0] chan_q [NCH];   // [0] upper mask, [1] lower mask

  // decode
  logic       aligned;
  logic       hit;
  logic [1:0] slot;
  op_e        op;

  irm_addr_decode #(
    .OFS_W   (OFS_W),
    .LEN_W   (LEN_W),
    .REG_BASE(REG_BASE)
  ) u_dec (
    .offset_i (req_offset),
    .len_i    (req_len),
    .aligned_o(aligned),
    .hit_o    (hit),
    .slot_o   (slot)
  );

  // lock rule units
  logic          bw_ok;
  logic [QW-1:0] bw_nxt;
  logic [QW-1:0] bw_ret;

  irm_bw_unit #(.BW_LIMIT(BW_LIMIT)) u_bw (
    .old_i(bw_q),
    .dat_i(req_data),
    .arg_i(req_arg),
    .ok_o (bw_ok),
    .nxt_o(bw_nxt),
    .ret_o(bw_ret)
  );

  logic          ch_ok  [NCH];
  logic [QW-1:0] ch_nxt [NCH];
  logic [QW-1:0] ch_ret [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    irm_chan_unit #(
      .PROTECT((c == 0) ? BCAST_MASK : 32'h0)
    ) u_ch (
      .old_i(chan_q[c]),
      .dat_i(req_data),
      .arg_i(req_arg),
      .ok_o (ch_ok[c]),
      .nxt_o(ch_nxt[c]),
      .ret_o(ch_ret[c])
    );
  end

  // named events for the checker
  logic          req_take;
  logic          lock_fire;
  logic          mgr_commit;
  logic          bw_commit;
  logic [NCH-1:0] ch_commit;
  logic [3:0]    code_d;
  logic [QW-1:0] value_d;

  always_comb begin
    op         = op_e'(req_op);
    req_take   = req_valid && !bus_reset;
    lock_fire  = req_take && aligned && hit && (op == OP_LOCK) && (req_ext == CAS);
    mgr_commit = lock_fire && (slot == SLOT_MGR) && (mgr_q == req_arg);
    bw_commit  = lock_fire && (slot == SLOT_BW) && bw_ok;
    ch_commit[0] = lock_fire && (slot == SLOT_CHH) && ch_ok[0];
    ch_commit[1] = lock_fire && (slot == SLOT_CHL) && ch_ok[1];
  end

  // response selection
  always_comb begin
    code_d  = RC_DONE;
    value_d = '0;
    if (!aligned || op == OP_RSVD) begin
      code_d = RC_TYPE;
    end else if (!hit) begin
      code_d = RC_ADDR;
    end else if (op == OP_WRITE) begin
      code_d = RC_TYPE;
    end else if (op == OP_READ) begin
      unique case (slot)
        SLOT_MGR: value_d = mgr_q;
        SLOT_BW:  value_d = bw_q;
        SLOT_CHH: value_d = chan_q[0];
        default:  value_d = chan_q[1];
      endcase
    end else if (req_ext != CAS) begin
      code_d = RC_TYPE;
    end else begin
      unique case (slot)
        SLOT_MGR: value_d = mgr_q;
        SLOT_BW:  value_d = bw_ret;
        SLOT_CHH: value_d = ch_ret[0];
        default:  value_d = ch_ret[1];
      endcase
    end
  end

  // state update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgr_q     <= MGR_RESET;
      bw_q      <= BW_DEF;
      chan_q[0] <= CHAN_HI_RESET;
      chan_q[1] <= CHAN_LO_RESET;
    end else if (bus_reset) begin
      mgr_q     <= MGR_RESET;
      bw_q      <= BW_DEF;
      chan_q[0] <= CHAN_HI_RESET;
      chan_q[1] <= CHAN_LO_RESET;
    end else begin
      if (mgr_commit) mgr_q <= req_data;
      if (bw_commit)  bw_q  <= bw_nxt;
      for (int c = 0; c < NCH; c++) begin
        if (ch_commit[c]) chan_q[c] <= ch_nxt[c];
      end
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RC_DONE;
      rsp_value <= '0;
    end else begin
      rsp_valid <= req_take;
      if (req_take) begin
        rsp_code  <= code_d;
        rsp_value <= value_d;
      end
    end
  end
endmodule

// File: rtl/irm_lock_regs_chk.sv
module irm_lock_regs_chk
  import irm_lock_pkg::*;
#(
  parameter int          OFS_W         = 12,
  parameter int          LEN_W         = 16,
  parameter int          EXT_W         = 16,
  parameter int unsigned CAS_CODE      = 2,
  parameter logic [31:0] MGR_RESET     = 32'h0000_003F,
  parameter int unsigned BW_RESET      = 4915,
  parameter int unsigned BW_LIMIT      = 8192,
  parameter logic [31:0] CHAN_HI_RESET = 32'hFFFF_FFFE,
  parameter logic [31:0] CHAN_LO_RESET = 32'hFFFF_FFFF,
  parameter logic [31:0] BCAST_MASK    = 32'h0000_0001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_reset,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic [OFS_W-1:0] req_offset,
  input logic [LEN_W-1:0] req_len,
  input logic [EXT_W-1:0] req_ext,
  input logic             hit,
  input logic             rsp_valid,
  input logic [3:0]       rsp_code,
  input logic [31:0]      mgr_q,
  input logic [31:0]      bw_q,
  input logic [31:0]      chan_hi,
  input logic [31:0]      chan_lo
);
  logic req_take;
  logic misaligned;
  assign req_take   = req_valid && !bus_reset;
  assign misaligned = ((req_offset[1:0] | req_len[1:0]) != 2'b00);

  p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (mgr_q == MGR_RESET && bw_q == 32'(BW_RESET) &&
                   chan_hi == CHAN_HI_RESET && chan_lo == CHAN_LO_RESET));

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_take |=> !rsp_valid);

  p_write_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && req_op == 2'd1 && hit && !misaligned) |=>
      (rsp_code == RC_TYPE && $stable(mgr_q) && $stable(bw_q) &&
       $stable(chan_hi) && $stable(chan_lo)));

  p_misaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && misaligned) |=> rsp_code == RC_TYPE);

  p_bad_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && req_op == 2'd2 && hit && !misaligned && req_len != '0 &&
     req_ext != EXT_W'(CAS_CODE)) |=>
      (rsp_code == RC_TYPE && $stable(mgr_q) && $stable(bw_q) &&
       $stable(chan_hi) && $stable(chan_lo)));

  p_bw_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bw_q < 32'(BW_LIMIT));

  p_bcast_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_hi & BCAST_MASK) == 32'h0);
endmodule

bind irm_lock_regs irm_lock_regs_chk #(
  .OFS_W        (OFS_W),
  .LEN_W        (LEN_W),
  .EXT_W        (EXT_W),
  .CAS_CODE     (CAS_CODE),
  .MGR_RESET    (MGR_RESET),
  .BW_RESET     (BW_RESET),
  .BW_LIMIT     (BW_LIMIT),
  .CHAN_HI_RESET(CHAN_HI_RESET),
  .CHAN_LO_RESET(CHAN_LO_RESET),
  .BCAST_MASK   (BCAST_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_reset (bus_reset),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_offset(req_offset),
  .req_len   (req_len),
  .req_ext   (req_ext),
  .hit       (hit),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .mgr_q     (mgr_q),
  .bw_q      (bw_q),
  .chan_hi   (chan_q[0]),
  .chan_lo   (chan_q[1])
);

// File: tb/irm_lock_regs_tb.sv
module irm_lock_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 34;

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  op;
    logic [11:0] ofs;
    logic [15:0] len;
    logic [15:0] ext;
    logic [31:0] dat;
    logic [31:0] arg;
    logic [3:0]  code;
    logic [31:0] val;
  } vec_t;

  // offsets: 0x21C manager, 0x220 bandwidth, 0x224 upper mask, 0x228 lower mask
  localparam vec_t TBL [NVEC] = '{
    '{8'd3,  2'd0, 12'h21C, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'h0000003F}, // R3
    '{8'd3,  2'd0, 12'h220, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'd4915},     // R3
    '{8'd3,  2'd0, 12'h224, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'hFFFFFFFE}, // R3
    '{8'd3,  2'd0, 12'h228, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'hFFFFFFFF}, // R3
    '{8'd7,  2'd2, 12'h21C, 16'd8, 16'd2, 32'h5,        32'h3F,       4'd0, 32'h3F},       // R7 match
    '{8'd7,  2'd2, 12'h21C, 16'd8, 16'd2, 32'h9,        32'h3F,       4'd0, 32'h5},        // R7 miss
    '{8'd7,  2'd0, 12'h21C, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'h5},        // R7
    '{8'd8,  2'd2, 12'h220, 16'd8, 16'd2, 32'd4915,     32'd4915,     4'd0, 32'd4915},     // R8
    '{8'd9,  2'd2, 12'h220, 16'd8, 16'd2, 32'd4815,     32'd4915,     4'd0, 32'd4915},     // R9 take 100
    '{8'd9,  2'd2, 12'h220, 16'd8, 16'd2, 32'd0,        32'd5000,     4'd0, 32'd4815},     // R9 too much
    '{8'd9,  2'd2, 12'h220, 16'd8, 16'd2, 32'd0,        32'd4815,     4'd0, 32'd4815},     // R9 exact drain
    '{8'd9,  2'd0, 12'h220, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'd0},        // R9
    '{8'd10, 2'd2, 12'h220, 16'd8, 16'd2, 32'd8191,     32'd0,        4'd0, 32'd0},        // R10 to 8191
    '{8'd10, 2'd2, 12'h220, 16'd8, 16'd2, 32'd1,        32'd0,        4'd0, 32'd8191},     // R10 hits limit
    '{8'd13, 2'd2, 12'h220, 16'd8, 16'd2, 32'd4915,     32'd8191,     4'd0, 32'd8191},     // R13 back to 4915
    '{8'd11, 2'd2, 12'h228, 16'd8, 16'd2, 32'hFFFFFFF0, 32'hFFFFFFFF, 4'd0, 32'hFFFFFFFF}, // R11 claim 4
    '{8'd11, 2'd2, 12'h228, 16'd8, 16'd2, 32'hFFFFFFFE, 32'hFFFFFFFF, 4'd0, 32'hFFFFFFF0}, // R11 stale
    '{8'd11, 2'd2, 12'h228, 16'd8, 16'd2, 32'hFFFFFFF8, 32'hFFFFFFF0, 4'd0, 32'hFFFFFFF0}, // R11 free one
    '{8'd11, 2'd0, 12'h228, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'hFFFFFFF8}, // R11
    '{8'd12, 2'd2, 12'h224, 16'd8, 16'd2, 32'hFFFFFFFF, 32'hFFFFFFFE, 4'd0, 32'hFFFFFFFE}, // R12 free ch31
    '{8'd11, 2'd2, 12'h224, 16'd8, 16'd2, 32'h7FFFFFFF, 32'hFFFFFFFE, 4'd0, 32'hFFFFFFFE}, // R11 upper claim
    '{8'd12, 2'd2, 12'h224, 16'd8, 16'd2, 32'hFFFFFFFF, 32'h7FFFFFFE, 4'd0, 32'h7FFFFFFE}, // R12 mixed free
    '{8'd12, 2'd0, 12'h224, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'hFFFFFFFE}, // R12
    '{8'd4,  2'd1, 12'h220, 16'd4, 16'd0, 32'h0,        32'h0,        4'd6, 32'h0},        // R4 write
    '{8'd4,  2'd0, 12'h220, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'd4915},     // R4 kept
    '{8'd4,  2'd1, 12'h21C, 16'd4, 16'd0, 32'h1,        32'h0,        4'd6, 32'h0},        // R4 write
    '{8'd4,  2'd0, 12'h21C, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'h5},        // R4 kept
    '{8'd4,  2'd0, 12'h22C, 16'd4, 16'd0, 32'h0,        32'h0,        4'd7, 32'h0},        // R4 above
    '{8'd4,  2'd2, 12'h218, 16'd8, 16'd2, 32'h0,        32'h0,        4'd7, 32'h0},        // R4 below
    '{8'd5,  2'd0, 12'h222, 16'd4, 16'd0, 32'h0,        32'h0,        4'd6, 32'h0},        // R5 offset
    '{8'd5,  2'd0, 12'h220, 16'd6, 16'd0, 32'h0,        32'h0,        4'd6, 32'h0},        // R5 length
    '{8'd6,  2'd2, 12'h220, 16'd8, 16'd1, 32'd0,        32'd4915,     4'd6, 32'h0},        // R6
    '{8'd6,  2'd0, 12'h220, 16'd4, 16'd0, 32'h0,        32'h0,        4'd0, 32'd4915},     // R6 kept
    '{8'd5,  2'd3, 12'h220, 16'd4, 16'd0, 32'h0,        32'h0,        4'd6, 32'h0}         // R5 op 3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_offset = '0;
  logic [15:0] req_len = '0;
  logic [15:0] req_ext = '0;
  logic [31:0] req_data = '0;
  logic [31:0] req_arg = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_code;
  logic [31:0] rsp_value;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irm_lock_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_offset(req_offset),
    .req_len   (req_len),
    .req_ext   (req_ext),
    .req_data  (req_data),
    .req_arg   (req_arg),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_value (rsp_value)
  );

  task automatic check(input int rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, got, exp);
    end
  endtask

  // one request: drive at a falling edge, response sampled at the next falling edge
  task automatic send(input logic [1:0] op, input logic [11:0] ofs,
                      input logic [15:0] len, input logic [15:0] ext,
                      input logic [31:0] dat, input logic [31:0] arg);
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    req_offset = ofs;
    req_len    = len;
    req_ext    = ext;
    req_data   = dat;
    req_arg    = arg;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic read_expect(input int rq, input logic [11:0] ofs,
                             input logic [31:0] exp);
    send(2'd0, ofs, 16'd4, 16'd0, 32'h0, 32'h0);
    check(rq, "read valid", {31'd0, rsp_valid}, 32'd1);
    check(rq, "read code", {28'd0, rsp_code}, 32'd0);
    check(rq, "read value", rsp_value, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 R2: idle after reset
    check(2, "valid during reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(2, "valid idle", {31'd0, rsp_valid}, 32'd0);
    read_expect(1, 12'h224, 32'hFFFFFFFE);

    // R2: single-cycle response
    @(negedge clk);
    check(2, "valid drops", {31'd0, rsp_valid}, 32'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      send(TBL[i].op, TBL[i].ofs, TBL[i].len, TBL[i].ext, TBL[i].dat, TBL[i].arg);
      check(int'(TBL[i].rq), $sformatf("vec %0d valid", i), {31'd0, rsp_valid}, 32'd1);
      check(int'(TBL[i].rq), $sformatf("vec %0d code", i), {28'd0, rsp_code}, {28'd0, TBL[i].code});
      check(int'(TBL[i].rq), $sformatf("vec %0d value", i), rsp_value, TBL[i].val);
    end

    // R2: a request in the bus reset cycle is dropped; R1: defaults reload
    read_expect(1, 12'h228, 32'hFFFFFFF8);
    @(negedge clk);
    bus_reset  = 1'b1;
    req_valid  = 1'b1;
    req_op     = 2'd2;
    req_offset = 12'h21C;
    req_len    = 16'd8;
    req_ext    = 16'd2;
    req_data   = 32'h7;
    req_arg    = 32'h3F;
    @(negedge clk);
    bus_reset  = 1'b0;
    req_valid  = 1'b0;
    check(2, "no response in bus reset", {31'd0, rsp_valid}, 32'd0);
    read_expect(1, 12'h21C, 32'h0000003F);
    read_expect(1, 12'h220, 32'd4915);
    read_expect(1, 12'h224, 32'hFFFFFFFE);
    read_expect(1, 12'h228, 32'hFFFFFFFF);

    // R13: back-to-back locks see each other's result
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_offset = 12'h220; req_len = 16'd8;
    req_ext = 16'd2; req_data = 32'd4900; req_arg = 32'd4915;
    @(negedge clk);
    check(13, "first lock", rsp_value, 32'd4915);
    req_data = 32'd4800; req_arg = 32'd4900;
    @(negedge clk);
    req_valid = 1'b0;
    check(13, "second lock sees first", rsp_value, 32'd4900);
    check(13, "second lock code", {28'd0, rsp_code}, 32'd0);
    read_expect(13, 12'h220, 32'd4800);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule